// File: doc/BRIEF.md
# Instruction Prefetch Line Buffer

This block sits between an instruction-fetch sequencer and a memory read port that supports bursts. With prefetching on, a fetch that misses loads an 8-doubleword line that starts at the requested address. Later fetches that land inside that line are answered from local storage, so they need no memory access. Each stored word has its own valid bit. A fetch is therefore answered as soon as its word has arrived, even while the rest of the line is still streaming in.

The fill uses the largest burst that the configured burst code allows. Code 3 fills the line with one 8-word burst. Code 2 fills it with two back-to-back 4-word bursts. Codes 0 and 1 give bursts shorter than four words, and with either of them the unit turns itself off: every fetch then becomes a single-word memory read, and nothing is buffered. The unit is also off while the enable input is low.

The line is discarded by the flush input, and by a memory-to-memory copy instruction unless that copy carries a no-flush flag. If a discard or a miss arrives while a fill is under way, the burst in flight is allowed to complete. Its data is dropped, and only then is a new fill started.

The controller has five states:
- FILL_IDLE: no memory traffic is pending.
- FILL_ISSUE: a burst request is presented to memory.
- FILL_RECV: the words of that burst are being received.
- BYP_ISSUE: a single-word request is presented to memory.
- BYP_RECV: the controller waits for that single word.

The transitions between them are:
- IDLE→BYP_ISSUE on a fetch while the unit is off.
- IDLE→FILL_ISSUE on a miss.
- FILL_ISSUE→FILL_RECV when memory accepts the request.
- FILL_RECV→FILL_ISSUE after a burst when the line still needs more words and there is no abort.
- FILL_RECV→IDLE after the last burst, or after an aborted burst.
- BYP_ISSUE→BYP_RECV when memory accepts the request.
- BYP_RECV→IDLE when the word arrives.

Top module: `insn_prefetch`

## Requirements
- R1: After reset, fetch_rsp_valid and mem_req_valid are low. fetch_rsp_valid is never high on two consecutive cycles. Every fetch gets exactly one response, and that response carries the memory word at the fetch address.
- R2: With cfg_pf_en low, every fetch issues one memory request at the fetch address with mem_req_len = 1.
- R3: With cfg_pf_en high and cfg_burst_code 0 or 1 (burst of 1 or 2 doublewords, below four), fetches behave as in R2.
- R4: With cfg_burst_code 3 (8 doublewords), a miss at address A issues exactly one request (A, 8). Fetches of A+1..A+7 then issue no further requests.
- R5: With cfg_burst_code 2 (4 doublewords), a miss at A issues (A, 4) and then (A+4, 4), and no other requests.
- R6: The first fetch of a fill is answered before all eight words of the line have been delivered.
- R7: A fetch outside [base, base+7] during a fill lets the burst in flight finish. It then starts a new fill at the new address and gets the correct data.
- R8: A flush_req pulse discards the line. The next fetch inside the old range issues a new request and returns the current memory contents. No response is given in the cycle after a flush.
- R9: copy_issue with copy_noflush low discards the line as in R8.
- R10: copy_issue with copy_noflush high leaves the line intact. A following fetch inside the range returns the buffered word and issues no request.
- R11: A flush during a fill drops the remaining words of the burst in flight and issues no further burst of that fill. The next request starts at the new fetch address.
- R12: Once mem_req_valid is raised, it stays high with stable address and length until mem_req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pf_en | input | 1 | Prefetch enable |
| cfg_burst_code | input | 2 | Burst length code: 0=1, 1=2, 2=4, 3=8 doublewords |
| flush_req | input | 1 | Discard the buffered line |
| copy_issue | input | 1 | A memory-to-memory copy instruction is executing |
| copy_noflush | input | 1 | The copy carries the no-flush flag |
| fetch_valid | input | 1 | Fetch request; held until the response |
| fetch_addr | input | AW | Doubleword fetch address |
| fetch_rsp_valid | output | 1 | One-cycle response strobe |
| fetch_rsp_data | output | DW | Instruction word |
| mem_req_valid | output | 1 | Memory burst request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Burst start address |
| mem_req_len | output | clog2(LINE_WORDS)+1 | Burst length in doublewords |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | DW | Read data word |

## Verification
The bench uses the default parameters: 16-bit addresses, 32-bit words, an 8-word line and a 4-word minimum burst. It varies cfg_burst_code at run time, so both the two-burst fill and the single-burst fill are exercised, along with both bypass codes. The memory model returns words two cycles apart and withholds ready on every third cycle. This keeps the fill open long enough for an early hit, for a miss in the middle of a fill and for a flush in the middle of a fill, and it holds requests pending so that request stability is tested. Memory contents change between phases, so stale and fresh data can be told apart.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;
    typedef enum logic [2:0] {
        FILL_IDLE,
        FILL_ISSUE,
        FILL_RECV,
        BYP_ISSUE,
        BYP_RECV
    } pf_state_e;
endpackage

// File: rtl/pf_line.sv
`timescale 1ns/1ps
module pf_line #(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          load,
    input  logic [AW-1:0]                 base_in,
    input  logic                          wr_en,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_idx,
    input  logic [DW-1:0]                 wr_data,
    input  logic [AW-1:0]                 rd_addr,
    output logic                          in_range,
    output logic                          hit,
    output logic [DW-1:0]                 rd_data
);
    localparam int IDXW = $clog2(LINE_WORDS);

    logic [AW-1:0]         base;
    logic                  live;
    logic [LINE_WORDS-1:0] vld;
    logic [DW-1:0]         words [LINE_WORDS];
    logic [AW-1:0]         diff;
    logic [IDXW-1:0]       off;

    always_comb begin
        diff     = rd_addr - base;
        off      = diff[IDXW-1:0];
        in_range = live && (diff < AW'(LINE_WORDS));
        hit      = in_range && vld[off];
        rd_data  = words[off];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            live <= 1'b0;
            vld  <= '0;
        end else if (clr) begin
            live <= 1'b0;
            vld  <= '0;
        end else if (load) begin
            base <= base_in;
            live <= 1'b1;
            vld  <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDXW'(i))
                words[i] <= wr_data;
        end
    end

    // R6
    word_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !clr && !load |=> vld[$past(wr_idx)]);
endmodule

// File: rtl/pf_ctrl.sv
`timescale 1ns/1ps
module pf_ctrl
    import pf_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LINE_WORDS = 8,
    parameter int MIN_BURST  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bypass,
    input  logic                          big_burst,
    input  logic                          kill,
    input  logic                          req_live,
    input  logic [AW-1:0]                 req_addr,
    input  logic                          hit,
    input  logic                          in_range,
    input  logic                          mem_req_ready,
    input  logic                          mem_rd_valid,
    output logic                          mem_req_valid,
    output logic [AW-1:0]                 mem_req_addr,
    output logic [$clog2(LINE_WORDS):0]   mem_req_len,
    output logic                          load_base,
    output logic                          line_clr,
    output logic                          wr_en,
    output logic [$clog2(LINE_WORDS)-1:0] wr_idx,
    output logic                          byp_done
);
    localparam int IDXW = $clog2(LINE_WORDS);
    localparam int LENW = IDXW + 1;

    pf_state_e       st, nxt;
    logic [AW-1:0]   fill_base;
    logic [LENW-1:0] words_req, beat, burst_left, blen;
    logic            abort, miss_now, abort_eff;

    assign blen      = big_burst ? LENW'(LINE_WORDS) : LENW'(MIN_BURST);
    assign miss_now  = req_live && !in_range;
    assign abort_eff = abort || kill || miss_now;
    assign wr_idx    = beat[IDXW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) st <= FILL_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt           = st;
        mem_req_valid = 1'b0;
        mem_req_addr  = fill_base + AW'(words_req);
        mem_req_len   = blen;
        load_base     = 1'b0;
        line_clr      = kill;
        wr_en         = 1'b0;
        byp_done      = 1'b0;
        unique case (st)
            FILL_IDLE: begin
                if (req_live && !kill) begin
                    if (bypass) begin
                        nxt      = BYP_ISSUE;
                        line_clr = 1'b1;
                    end else if (!hit) begin
                        nxt       = FILL_ISSUE;
                        load_base = 1'b1;
                    end
                end
            end
            FILL_ISSUE: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) nxt = FILL_RECV;
            end
            FILL_RECV: begin
                if (mem_rd_valid) begin
                    wr_en = !abort_eff;
                    if (burst_left == LENW'(1)) begin
                        if (abort_eff) begin
                            nxt      = FILL_IDLE;
                            line_clr = 1'b1;
                        end else if (words_req == LENW'(LINE_WORDS)) begin
                            nxt = FILL_IDLE;
                        end else begin
                            nxt = FILL_ISSUE;
                        end
                    end
                end
            end
            BYP_ISSUE: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = fill_base;
                mem_req_len   = LENW'(1);
                if (mem_req_ready) nxt = BYP_RECV;
            end
            BYP_RECV: begin
                if (mem_rd_valid) begin
                    byp_done = 1'b1;
                    nxt      = FILL_IDLE;
                end
            end
            default: nxt = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_base  <= '0;
            words_req  <= '0;
            beat       <= '0;
            burst_left <= '0;
            abort      <= 1'b0;
        end else begin
            if (st == FILL_IDLE && nxt != FILL_IDLE) begin
                fill_base <= req_addr;
                words_req <= '0;
                beat      <= '0;
                abort     <= 1'b0;
            end
            if ((st == FILL_ISSUE || st == FILL_RECV) && (kill || miss_now))
                abort <= 1'b1;
            if (st == FILL_ISSUE && mem_req_ready) begin
                words_req  <= words_req + blen;
                burst_left <= blen;
            end
            if (st == FILL_RECV && mem_rd_valid) begin
                beat       <= beat + LENW'(1);
                burst_left <= burst_left - LENW'(1);
            end
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len));

    // R11
    kill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FILL_ISSUE || st == FILL_RECV) && kill |=> !wr_en);
endmodule

// File: rtl/insn_prefetch.sv
`timescale 1ns/1ps
module insn_prefetch #(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int LINE_WORDS = 8,
    parameter int MIN_BURST  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_pf_en,
    input  logic [1:0]                  cfg_burst_code,
    input  logic                        flush_req,
    input  logic                        copy_issue,
    input  logic                        copy_noflush,
    input  logic                        fetch_valid,
    input  logic [AW-1:0]               fetch_addr,
    output logic                        fetch_rsp_valid,
    output logic [DW-1:0]               fetch_rsp_data,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic [AW-1:0]               mem_req_addr,
    output logic [$clog2(LINE_WORDS):0] mem_req_len,
    input  logic                        mem_rd_valid,
    input  logic [DW-1:0]               mem_rd_data
);
    localparam int IDXW = $clog2(LINE_WORDS);

    logic            flush_now, bypass, big_burst, req_live, take;
    logic            line_hit, line_in_range, load_base, line_clr, wr_en, byp_done;
    logic [IDXW-1:0] wr_idx;
    logic [DW-1:0]   line_data;
    logic [7:0]      burst_words;

    assign burst_words = 8'd1 << cfg_burst_code;
    assign bypass      = !cfg_pf_en || (int'(burst_words) < MIN_BURST);
    assign big_burst   = int'(burst_words) >= LINE_WORDS;
    assign flush_now   = flush_req || (copy_issue && !copy_noflush);
    assign req_live    = fetch_valid && !fetch_rsp_valid;
    assign take        = req_live && line_hit && !bypass && !flush_now;

    pf_line #(.AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)) u_line (
        .clk(clk), .rst_n(rst_n), .clr(line_clr), .load(load_base),
        .base_in(fetch_addr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(mem_rd_data), .rd_addr(fetch_addr),
        .in_range(line_in_range), .hit(line_hit), .rd_data(line_data)
    );

    pf_ctrl #(.AW(AW), .LINE_WORDS(LINE_WORDS), .MIN_BURST(MIN_BURST)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .big_burst(big_burst),
        .kill(flush_now), .req_live(req_live), .req_addr(fetch_addr),
        .hit(line_hit), .in_range(line_in_range),
        .mem_req_ready(mem_req_ready), .mem_rd_valid(mem_rd_valid),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_len(mem_req_len), .load_base(load_base), .line_clr(line_clr),
        .wr_en(wr_en), .wr_idx(wr_idx), .byp_done(byp_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_rsp_valid <= 1'b0;
            fetch_rsp_data  <= '0;
        end else begin
            fetch_rsp_valid <= take || byp_done;
            fetch_rsp_data  <= byp_done ? mem_rd_data : line_data;
        end
    end

    // R1
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rsp_valid |=> !fetch_rsp_valid);

    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_now && !bypass && !mem_rd_valid |=> !fetch_rsp_valid);
endmodule

// File: tb/sim_insn_prefetch.sv
`timescale 1ns/1ps
module sim_insn_prefetch;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_pf_en = 1'b0;
    logic [1:0]    cfg_burst_code = 2'd3;
    logic          flush_req = 1'b0, copy_issue = 1'b0, copy_noflush = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_rsp_valid;
    logic [DW-1:0] fetch_rsp_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [3:0]    mem_req_len;
    logic          mem_rd_valid = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;

    insn_prefetch u0 (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0, gen = 0, cyc = 0, delivered = 0, prot_err = 0;
    bit done = 1'b0;
    logic [DW-1:0] sb_q[$];
    string         tag_q[$];
    logic [DW-1:0] wq_data[$];
    int            wq_stamp[$];
    logic [AW-1:0] rl_addr[$];
    int            rl_len[$];

    function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
        return {a, a ^ 16'hC3A5} ^ (32'(gen) * 32'h01010101);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // memory model: words two cycles apart, ready withheld every third cycle
    initial begin
        bit            pend = 1'b0;
        logic [AW-1:0] p_addr = '0;
        logic [3:0]    p_len = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (pend && !(mem_req_valid && mem_req_addr == p_addr && mem_req_len == p_len))
                prot_err++;
            mem_req_ready = (cyc % 3) != 0;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                rl_addr.push_back(mem_req_addr);
                rl_len.push_back(int'(mem_req_len));
                for (int i = 0; i < int'(mem_req_len); i++) begin
                    wq_data.push_back(mdata(mem_req_addr + AW'(i)));
                    wq_stamp.push_back(cyc + 2 + 2 * i);
                end
                pend = 1'b0;
            end else begin
                pend   = rst_n && mem_req_valid;
                p_addr = mem_req_addr;
                p_len  = mem_req_len;
            end
            if (wq_data.size() > 0 && wq_stamp[0] <= cyc) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = wq_data.pop_front();
                void'(wq_stamp.pop_front());
            end else begin
                mem_rd_valid = 1'b0;
            end
        end
    end

    always @(posedge clk) if (mem_rd_valid) delivered <= delivered + 1;

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && fetch_rsp_valid) begin
            if (sb_q.size() == 0) chk(1'b0, "R1 unexpected response", fetch_rsp_data, 0);
            else begin
                logic [DW-1:0] e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                chk(fetch_rsp_data === e, t, fetch_rsp_data, e);
            end
        end
    end

    task automatic fetch(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        sb_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        do @(negedge clk); while (!fetch_rsp_valid);
        fetch_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
        rl_addr.delete();
        rl_len.delete();
    endtask

    task automatic pulse(input bit f, input bit c, input bit nf);
        @(negedge clk);
        flush_req = f; copy_issue = c; copy_noflush = nf;
        @(negedge clk);
        flush_req = 0; copy_issue = 0; copy_noflush = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        int d0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fetch_rsp_valid, "R1 reset rsp", fetch_rsp_valid, 0);
        chk(!mem_req_valid, "R1 reset req", mem_req_valid, 0);

        // R2: disabled
        settle();
        fetch(16'h0010, mdata(16'h0010), "R2 data a");
        fetch(16'h0011, mdata(16'h0011), "R2 data b");
        settle_noclr();
        chk(rl_len.size() == 2 && rl_addr[0] == 16'h0010 && rl_len[0] == 1 && rl_addr[1] == 16'h0011 && rl_len[1] == 1,
            "R2 single-word requests", rl_len.size(), 2);

        // R3: enabled with short burst code
        cfg_pf_en = 1'b1; cfg_burst_code = 2'd1;
        settle();
        fetch(16'h0020, mdata(16'h0020), "R3 data");
        fetch(16'h0021, mdata(16'h0021), "R3 data next");
        settle_noclr();
        chk(rl_len.size() == 2 && rl_len[0] == 1 && rl_len[1] == 1, "R3 bypass requests", rl_len.size(), 2);

        // R4 / R6: 8-word burst
        cfg_burst_code = 2'd3;
        settle();
        d0 = delivered;
        fetch(16'h0100, mdata(16'h0100), "R4 first word");
        chk((delivered - d0) < 8, "R6 early hit", delivered - d0, 7);
        for (int i = 1; i < 8; i++) fetch(16'h0100 + AW'(i), mdata(16'h0100 + AW'(i)), "R4 sequential hit");
        settle_noclr();
        chk(rl_len.size() == 1 && rl_addr[0] == 16'h0100 && rl_len[0] == 8, "R4 one 8-word burst", rl_len.size(), 1);

        // R5: 4-word bursts
        cfg_burst_code = 2'd2;
        settle();
        for (int i = 0; i < 8; i++) fetch(16'h0200 + AW'(i), mdata(16'h0200 + AW'(i)), "R5 line word");
        settle_noclr();
        chk(rl_len.size() == 2 && rl_addr[0] == 16'h0200 && rl_len[0] == 4 && rl_addr[1] == 16'h0204 && rl_len[1] == 4,
            "R5 two 4-word bursts", rl_len.size(), 2);

        // R7: miss during fill
        cfg_burst_code = 2'd3;
        settle();
        fetch(16'h0300, mdata(16'h0300), "R7 first line");
        fetch(16'h0400, mdata(16'h0400), "R7 new line");
        fetch(16'h0401, mdata(16'h0401), "R7 new line hit");
        settle_noclr();
        chk(rl_len.size() == 2 && rl_addr[1] == 16'h0400, "R7 refill address", rl_addr.size() > 1 ? rl_addr[1] : 0, 16'h0400);

        // R8: flush input
        settle();
        gen = 1;
        pulse(1'b1, 1'b0, 1'b0);
        fetch(16'h0402, mdata(16'h0402), "R8 fresh data");
        settle_noclr();
        chk(rl_len.size() == 1 && rl_addr[0] == 16'h0402, "R8 refetch", rl_len.size(), 1);

        // R10: copy with no-flush
        settle();
        begin
            logic [DW-1:0] old;
            old = mdata(16'h0403);
            gen = 2;
            pulse(1'b0, 1'b1, 1'b1);
            fetch(16'h0403, old, "R10 buffered word kept");
        end
        settle_noclr();
        chk(rl_len.size() == 0, "R10 no request", rl_len.size(), 0);

        // R9: copy without no-flush
        settle();
        pulse(1'b0, 1'b1, 1'b0);
        fetch(16'h0404, mdata(16'h0404), "R9 fresh data");
        settle_noclr();
        chk(rl_len.size() == 1 && rl_addr[0] == 16'h0404, "R9 refetch", rl_len.size(), 1);

        // R11: flush during a 4-word fill
        cfg_burst_code = 2'd2;
        settle();
        fetch(16'h0500, mdata(16'h0500), "R11 first word");
        gen = 3;
        pulse(1'b1, 1'b0, 1'b0);
        fetch(16'h0501, mdata(16'h0501), "R11 no stale data");
        settle_noclr();
        chk(rl_len.size() == 3 && rl_addr[1] == 16'h0501, "R11 fill stopped",
            rl_addr.size() > 1 ? rl_addr[1] : 0, 16'h0501);

        chk(prot_err == 0, "R12 request held until ready", prot_err, 0);
        chk(sb_q.size() == 0, "R1 every fetch answered", sb_q.size(), 0);
        report();
    end

    task automatic settle_noclr();
        repeat (40) @(negedge clk);
    endtask
endmodule